// File: doc/BRIEF.md
# Key-Sequence Serviced Watchdog Timer

This peripheral guards a system against software that has stopped making progress. Software reaches it through a 16-bit register bus with two registers. The control register holds an 8-bit timeout, a write-once enable and a bit that freezes the count while the system is in low-power mode. The service register takes the refresh keys. The countdown advances on an external slow tick enable that pulses twice per second. A field value of N therefore gives (N+1)/2 seconds before expiry.

Once the enable is set, software cannot stop the timer. It keeps the timer alive by writing 0x5555 and then 0xAAAA to the service register. When the count runs out, the block drives a system reset request for a fixed number of clock cycles. It then stays in the expired state until its own hardware reset.

The register bus is plain control traffic and has no back-pressure. A write completes in the cycle in which `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and is zero otherwise.

Top module: `keyseq_wdog`

## Requirements
- R1: After hardware reset, the control register reads 0x0000, the enable is off, the count is zero and `sys_rst_o` is low.
- R2: The control register sits at byte offset 0x0 and the service register at offset 0x2. Every control bit reads back as last written, except that the enable bit never returns to 0. The service register and any other offset read 0x0000.
- R3: Control bits [15:8] hold the timeout field T. Setting the enable loads the count with T+1, using the T written in that same write. The count drops by one on each `tick_en` pulse while enabled. Expiry occurs on the (T+1)-th tick.
- R4: Control bit 2 is the enable. Once it is 1, no software write can clear it.
- R5: A write of 0x5555 to the service register followed by a write of 0xAAAA, with no other service write between them, reloads the count with T+1.
- R6: A service write of any other value, or a 0xAAAA that is not preceded by 0x5555, clears the key state and does not reload the count.
- R7: When control bit 0 is 1 and `lowpwr_i` is high, ticks do not decrement the count. When bit 0 is 0, `lowpwr_i` has no effect.
- R8: After the enable is set, a new timeout value does not change the running count. It takes effect at the next valid key pair.
- R9: One clock cycle after the count reaches zero while enabled, `sys_rst_o` goes high for exactly RST_CYCLES clock cycles. The block then stays expired and gives no further pulses, and key pairs do not restart it, until hardware reset.
- R10: The largest field value, 255, gives 256 ticks before expiry.
- R11: While the enable is off, ticks and key pairs have no effect and no reset is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Byte offset: 0 = control, 2 = service |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| tick_en | input | 1 | Half-second tick enable, one clock wide |
| lowpwr_i | input | 1 | Low-power mode indication |
| sys_rst_o | output | 1 | System reset request |

## Verification
Internal faults in this block appear at the ports only through the timing of `sys_rst_o` or through control readback.

- A count loaded off by one, a missed reload or a reload that should not happen moves the reset edge by at least one tick. It shows on the first expiry after the fault.
- A key state that is not cleared causes a reload that should not happen, and the reset edge then arrives late.
- A lost enable shows at once in the control readback, and also as a reset that never comes.
- A trip latch that is not sticky shows as a second reset pulse within one tick.

// File: rtl/keyseq_wdog_pkg.sv
package keyseq_wdog_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 2'd2;
  localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;
  localparam int unsigned BIT_FRZ  = 0;
  localparam int unsigned BIT_EN   = 2;
  localparam int unsigned TO_LSB   = 8;
endpackage

// File: rtl/keyseq_wdog_regs.sv
module keyseq_wdog_regs
  import keyseq_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              start_o
);
  logic [DATA_W-1:0] ctrl_q;

  assign start_o = wr_ctrl && wdata[BIT_EN] && !ctrl_q[BIT_EN];
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q         <= wdata;
      ctrl_q[BIT_EN] <= wdata[BIT_EN] | ctrl_q[BIT_EN];
    end
  end

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[BIT_EN] |=> ctrl_q[BIT_EN]);
  // R4
  en_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[BIT_EN]) |-> $past(start_o));
endmodule

// File: rtl/keyseq_wdog_keyseq.sv
module keyseq_wdog_keyseq
  import keyseq_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              reload_o
);
  logic armed_q;

  assign reload_o = svc_wr && armed_q && (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (svc_wr) armed_q <= (wdata == KEY_ARM);
  end

  // R6
  reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> !armed_q);
  // R5
  armed_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_wr));
endmodule

// File: rtl/keyseq_wdog_counter.sv
module keyseq_wdog_counter #(
  parameter int unsigned TO_W       = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            freeze,
  input  logic            lowpwr,
  input  logic            tick,
  input  logic            load,
  input  logic [TO_W-1:0] load_val,
  output logic            sys_rst_o
);
  localparam int unsigned CNT_W = TO_W + 1;
  localparam int unsigned PLS_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PLS_W-1:0] pls_q;
  logic             trip_q;
  logic             halted;
  logic             expire;

  assign halted    = freeze && lowpwr;
  assign expire    = en && !trip_q && (cnt_q == '0);
  assign sys_rst_o = (pls_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pls_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (load && !trip_q)
        cnt_q <= {1'b0, load_val} + CNT_W'(1);
      else if (en && tick && !halted && cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
      if (expire) begin
        trip_q <= 1'b1;
        pls_q  <= PLS_W'(RST_CYCLES);
      end else if (pls_q != '0) begin
        pls_q <= pls_q - PLS_W'(1);
      end
    end
  end

  // R9
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> trip_q);
  // R9
  rst_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> trip_q);
  // R3
  rst_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(cnt_q) == '0);
  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
  import keyseq_wdog_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic              lowpwr_i,
  output logic              sys_rst_o
);
  localparam int unsigned TO_W = DATA_W - TO_LSB;

  logic [DATA_W-1:0] ctrl;
  logic              wr_ctrl, wr_svc, start, reload, load;
  logic [TO_W-1:0]   load_val;

  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
  assign wr_svc    = bus_sel && bus_wr && (bus_addr == OFS_SVC);
  assign bus_rdata = (bus_sel && bus_addr == OFS_CTRL) ? ctrl : '0;

  keyseq_wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .ctrl_o(ctrl), .start_o(start));

  keyseq_wdog_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .svc_wr(wr_svc), .wdata(bus_wdata),
    .reload_o(reload));

  assign load     = start || (reload && ctrl[BIT_EN]);
  assign load_val = start ? bus_wdata[DATA_W-1:TO_LSB] : ctrl[DATA_W-1:TO_LSB];

  keyseq_wdog_counter #(.TO_W(TO_W), .RST_CYCLES(RST_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl[BIT_EN]), .freeze(ctrl[BIT_FRZ]),
    .lowpwr(lowpwr_i), .tick(tick_en), .load(load), .load_val(load_val),
    .sys_rst_o(sys_rst_o));

  // R11
  no_rst_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[BIT_EN] |-> !sys_rst_o);
endmodule

// File: tb/keyseq_wdog_bench.sv
module keyseq_wdog_bench;
  localparam int RSTC = 16;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, tick_en = 0, lowpwr_i = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic sys_rst_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyseq_wdog #(.RST_CYCLES(RSTC)) u_keyseq_wdog (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask
  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask
  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 v = bus_rdata; bus_sel = 0;
  endtask
  task automatic tk(bit lp = 0);
    @(negedge clk); tick_en = 1; lowpwr_i = lp;
    @(negedge clk); tick_en = 0;
  endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) tk(); endtask
  task automatic pair(); wr(2, 16'h5555); wr(2, 16'hAAAA); endtask
  task automatic hw_reset();
    @(negedge clk); rst_n = 0; lowpwr_i = 0; repeat (2) @(negedge clk); rst_n = 1;
  endtask
  function automatic logic [15:0] ctl(int t, bit en, bit frz, logic [4:0] spare);
    return {t[7:0], spare, en, 1'b0, frz};
  endfunction
  // count remaining n ticks: n-1 without reset, n-th fires
  task automatic expire_after(int n, string req);
    ticks(n - 1); @(negedge clk); chk(!sys_rst_o, req, sys_rst_o, 0);
    tk(); @(negedge clk); chk(sys_rst_o, req, sys_rst_o, 1);
  endtask

  initial begin
    logic [15:0] v;
    int hi;
    void'($urandom(32'd4242));
    hw_reset();
    // R1
    rd(0, v); chk(v == 0, "R1", v, 0); chk(!sys_rst_o, "R1", sys_rst_o, 0);
    // R2 readback and service read zero
    wr(0, 16'h37A9); rd(0, v); chk(v == 16'h37A9, "R2", v, 16'h37A9);
    wr(2, 16'h1234); rd(2, v); chk(v == 0, "R2", v, 0);
    // R11 ticks ignored while disabled
    pair(); ticks(300); @(negedge clk); chk(!sys_rst_o, "R11", sys_rst_o, 0);
    // R3, R9 basic expiry with T=2 and pulse width
    hw_reset(); wr(0, ctl(2, 1, 0, 5'h0B));
    expire_after(3, "R3");
    hi = 1; while (sys_rst_o && hi < 100) begin @(negedge clk); if (sys_rst_o) hi++; end
    chk(hi == RSTC, "R9", hi, RSTC);
    pair(); ticks(10); @(negedge clk); chk(!sys_rst_o, "R9", sys_rst_o, 0);
    // R4 enable sticky
    hw_reset(); wr(0, ctl(3, 1, 0, 0)); wr(0, ctl(3, 0, 0, 5'h15));
    rd(0, v); chk(v == ctl(3, 1, 0, 5'h15), "R4", v, ctl(3, 1, 0, 5'h15));
    expire_after(4, "R4");
    // R5 key pair reloads
    hw_reset(); wr(0, ctl(2, 1, 0, 0)); ticks(2); pair();
    expire_after(3, "R5");
    // R6 wrong orders, junk and lone FIRE do not reload
    hw_reset(); wr(0, ctl(2, 1, 0, 0)); ticks(2);
    wr(2, 16'hAAAA); wr(2, 16'h5555); wr(2, 16'h1234); wr(2, 16'hAAAA);
    expire_after(1, "R6");
    // R7 freeze with lowpwr, and no freeze when bit0 clear
    hw_reset(); wr(0, ctl(1, 1, 1, 0));
    for (int i = 0; i < 20; i++) tk(1);
    @(negedge clk); chk(!sys_rst_o, "R7", sys_rst_o, 0);
    expire_after(2, "R7");
    hw_reset(); wr(0, ctl(1, 1, 0, 0)); tk(1); tk(1); @(negedge clk);
    chk(sys_rst_o, "R7", sys_rst_o, 1);
    // R8 timeout change applies at next reload
    hw_reset(); wr(0, ctl(2, 1, 0, 0)); wr(0, ctl(9, 1, 0, 0));
    ticks(1); expire_after(2, "R8");
    hw_reset(); wr(0, ctl(2, 1, 0, 0)); wr(0, ctl(5, 1, 0, 0)); pair();
    expire_after(6, "R8");
    // R10 maximum field
    hw_reset(); wr(0, ctl(255, 1, 0, 0)); expire_after(256, "R10");
    // random rounds checked against a bench model (R3 R5 R6 R7)
    for (int r = 0; r < 8; r++) begin
      int t, e; bit frz, lp;
      t = $urandom_range(0, 10); frz = $urandom_range(0, 1);
      hw_reset(); wr(0, ctl(t, 1, frz, 0)); e = t + 1;
      for (int s = 0; s < 60 && e > 0; s++) begin
        case ($urandom_range(0, 3))
          0, 1: begin lp = $urandom_range(0, 1); tk(lp); if (!(frz && lp)) e--; end
          2: begin pair(); e = t + 1; end
          default: wr(2, 16'h0F0F ^ 16'($urandom_range(0, 255)));
        endcase
        @(negedge clk);
        chk(sys_rst_o == (e == 0), "R3", sys_rst_o, (e == 0));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule